// File: doc/BRIEF.md
# Link Training Ordered-Set Sequencer

This block is the transmit half of a training sequencer for a 5 Gb/s serial link. It feeds a 32-bit parallel symbol bus into a PHY-facing interface. Each byte lane has its own control-character flag. Once a start pulse marks the end of the low-frequency signalling phase, the block walks through three transmit stages and then a terminal state. First it sends a long run of receiver-equalization training words. Next it sends a block of first-type training ordered sets. Then it sends a block of second-type training ordered sets whose control byte carries the loopback and hot-reset requests. Finally it signals that loopback has been reached.

The sink applies back-pressure through a valid/ready handshake. A word leaves the block only in a cycle where both valid and ready are high. Until then the offered word stays unchanged. The repeat count of each stage is a parameter. The defaults match the link's training lengths: 65536 equalization sequences, 256 first-type sets and 256 second-type sets. A bench can shrink them for quick runs.

Top module: `lts_sequencer`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the idle stage (code 0), with `tx_valid` low and `loopback_reached` low.
- R2: A `start` pulse sampled while idle moves the block to the equalization stage on the next cycle, with `tx_valid` high and the first word offered. `start` has no effect in any other stage.
- R3: The equalization stage offers `EQ_REPEATS` sequences (default 65536) of eight words each: BCFF17C0, 14B2E702, 82726E28, A6BE6DBF, then 4A4A4A4A four times.
- R4: The first-type set stage offers `TS1_REPEATS` sets (default 256) of four words each: BCBCBCBC, 00004A4A, 4A4A4A4A, 4A4A4A4A.
- R5: The second-type set stage offers `TS2_REPEATS` sets (default 256) of four words each: BCBCBCBC, {00, ctl, 4545}, 45454545, 45454545. The control byte `ctl` sits in bits [15:8] of the second word. Its bit 2 is the loopback request, its bit 0 is the hot-reset request, and every other bit is zero. Both request inputs are captured on the accepted start pulse and held for the whole run.
- R6: Words are big-endian: bits [31:24] hold the first byte on the wire. `tx_kflag[i]` belongs to byte `tx_data[8*i+7:8*i]` and is high only when that byte is 0xBC while `tx_valid` is high. It is zero in every other case.
- R7: Word and repeat positions advance only in a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, the offered word and the stage stay unchanged.
- R8: Stages run strictly in the order idle (0), equalization (1), first-type sets (2), second-type sets (3), loopback (4), and `stage` reports the current code. Each stage starts at its first word after the previous stage's last word is accepted.
- R9: Once the final word of the last second-type set is accepted, the block enters stage 4. `loopback_reached` then goes high and stays high until reset, and `tx_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins training when sampled while idle |
| loopback_req | input | 1 | Loopback request, captured at start |
| hot_reset_req | input | 1 | Hot-reset request, captured at start |
| tx_ready | input | 1 | Sink accepts the offered word |
| tx_valid | output | 1 | A training word is offered |
| tx_data | output | 32 | Offered word, first byte in [31:24] |
| tx_kflag | output | 4 | Per-lane control-character flag |
| stage | output | 3 | Current stage code |
| loopback_reached | output | 1 | Training finished, loopback entered |

## Verification
The embedded assertions check several properties on every cycle. Stage codes only ever step forward by one. A stalled word holds its value. Counters stay inside their wrap limits. The flag lanes take only the comma patterns the training words can produce. The terminal state is sticky and silent. Whether each word has the right value, whether the repeat counts are exact, and whether the request bits captured at start appear in the control byte can only be shown by the bench. It compares every offered word against its own model, under random back-pressure and with request inputs that change after start.

// File: rtl/lts_pkg.sv
package lts_pkg;

   localparam int LTS_LANES  = 4;
   localparam int LTS_WORD_W = 8 * LTS_LANES;
   localparam logic [7:0] LTS_COMMA = 8'hBC;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_EQ   = 3'd1,
      ST_TS1  = 3'd2,
      ST_TS2  = 3'd3,
      ST_LOOP = 3'd4
   } lts_stage_e;

   function automatic logic [LTS_WORD_W-1:0] lts_word(
      input lts_stage_e st,
      input logic [2:0] idx,
      input logic       lb,
      input logic       hr);
      logic [LTS_WORD_W-1:0] w;
      w = '0;
      unique case (st)
         ST_EQ: begin
            unique case (idx)
               3'd0:    w = 32'hBCFF_17C0;
               3'd1:    w = 32'h14B2_E702;
               3'd2:    w = 32'h8272_6E28;
               3'd3:    w = 32'hA6BE_6DBF;
               default: w = 32'h4A4A_4A4A;
            endcase
         end
         ST_TS1: begin
            unique case (idx)
               3'd0:    w = 32'hBCBC_BCBC;
               3'd1:    w = 32'h0000_4A4A;
               default: w = 32'h4A4A_4A4A;
            endcase
         end
         ST_TS2: begin
            unique case (idx)
               3'd0:    w = 32'hBCBC_BCBC;
               3'd1:    w = {8'h00, 5'b00000, lb, 1'b0, hr, 16'h4545};
               default: w = 32'h4545_4545;
            endcase
         end
         default: w = '0;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/lts_counter.sv
module lts_counter #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt,
   output logic         last
);

   generate
      if (W < 1 || W > 32) begin : g_bad_width
         $error("lts_counter: W out of range");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (inc)
         cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
   end

   assign cnt  = cnt_q;
   assign last = (cnt_q == limit);

   // R7: position never passes its wrap point
   a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= limit);

   // R7: position moves only on an accepted word
   a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(cnt_q));

endmodule

// File: rtl/lts_pattern.sv
module lts_pattern
   import lts_pkg::*;
#(
   parameter int LANES = LTS_LANES
) (
   input  lts_stage_e         st,
   input  logic               active,
   input  logic [2:0]         idx,
   input  logic               lb,
   input  logic               hr,
   output logic [8*LANES-1:0] data,
   output logic [LANES-1:0]   kflag
);

   generate
      if (LANES != LTS_LANES) begin : g_bad_lanes
         $error("lts_pattern: training words are defined for four lanes");
      end
   endgenerate

   assign data = active ? lts_word(st, idx, lb, hr) : '0;

   genvar ln;
   generate
      for (ln = 0; ln < LANES; ln++) begin : g_lane
         assign kflag[ln] = active && (data[8*ln +: 8] == LTS_COMMA);
      end
   endgenerate

endmodule

// File: rtl/lts_sequencer.sv
module lts_sequencer
   import lts_pkg::*;
#(
   parameter int EQ_REPEATS  = 65536,
   parameter int TS1_REPEATS = 256,
   parameter int TS2_REPEATS = 256
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        start,
   input  logic        loopback_req,
   input  logic        hot_reset_req,
   input  logic        tx_ready,
   output logic        tx_valid,
   output logic [31:0] tx_data,
   output logic [3:0]  tx_kflag,
   output logic [2:0]  stage,
   output logic        loopback_reached
);

   localparam int MAX_A  = (EQ_REPEATS > TS1_REPEATS) ? EQ_REPEATS : TS1_REPEATS;
   localparam int MAXR   = (MAX_A > TS2_REPEATS) ? MAX_A : TS2_REPEATS;
   localparam int RW     = (MAXR > 1) ? $clog2(MAXR) : 1;
   localparam int WW     = 3;
   localparam logic [WW-1:0] EQ_LAST_W = WW'(7);
   localparam logic [WW-1:0] TS_LAST_W = WW'(3);

   generate
      if (EQ_REPEATS < 1 || TS1_REPEATS < 1 || TS2_REPEATS < 1) begin : g_bad_reps
         $error("lts_sequencer: every repeat count must be at least one");
      end
      if (RW > 32) begin : g_bad_rw
         $error("lts_sequencer: repeat counts too large");
      end
   endgenerate

   lts_stage_e   stage_q, stage_d;
   logic         lb_q, hr_q;
   logic [WW-1:0] word_limit, word_idx;
   logic [RW-1:0] rep_limit, rep_idx;
   logic         word_last, rep_last;
   logic         active, accept, set_done, stage_done;

   assign active     = (stage_q == ST_EQ) || (stage_q == ST_TS1) || (stage_q == ST_TS2);
   assign accept     = active && tx_ready;
   assign set_done   = accept && word_last;
   assign stage_done = set_done && rep_last;
   assign word_limit = (stage_q == ST_EQ) ? EQ_LAST_W : TS_LAST_W;

   always_comb begin
      unique case (stage_q)
         ST_EQ:   rep_limit = RW'(EQ_REPEATS - 1);
         ST_TS1:  rep_limit = RW'(TS1_REPEATS - 1);
         ST_TS2:  rep_limit = RW'(TS2_REPEATS - 1);
         default: rep_limit = '0;
      endcase
   end

   lts_counter #(.W(WW)) u_word (
      .clk   (clk),
      .rst   (rst),
      .inc   (accept),
      .limit (word_limit),
      .cnt   (word_idx),
      .last  (word_last)
   );

   lts_counter #(.W(RW)) u_rep (
      .clk   (clk),
      .rst   (rst),
      .inc   (set_done),
      .limit (rep_limit),
      .cnt   (rep_idx),
      .last  (rep_last)
   );

   always_comb begin
      stage_d = stage_q;
      unique case (stage_q)
         ST_IDLE: if (start)      stage_d = ST_EQ;
         ST_EQ:   if (stage_done) stage_d = ST_TS1;
         ST_TS1:  if (stage_done) stage_d = ST_TS2;
         ST_TS2:  if (stage_done) stage_d = ST_LOOP;
         default: stage_d = stage_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= ST_IDLE;
         lb_q    <= 1'b0;
         hr_q    <= 1'b0;
      end else begin
         stage_q <= stage_d;
         if (stage_q == ST_IDLE && start) begin
            lb_q <= loopback_req;
            hr_q <= hot_reset_req;
         end
      end
   end

   lts_pattern #(.LANES(LTS_LANES)) u_pat (
      .st     (stage_q),
      .active (active),
      .idx    (word_idx),
      .lb     (lb_q),
      .hr     (hr_q),
      .data   (tx_data),
      .kflag  (tx_kflag)
   );

   assign tx_valid         = active;
   assign stage            = stage_q;
   assign loopback_reached = (stage_q == ST_LOOP);

   // R8: stage codes only step forward by one
   a_r8_stage_order: assert property (@(posedge clk) disable iff (rst)
      (stage != $past(stage)) |-> (stage == 3'($past(stage) + 3'd1)));

   // R7: a stalled word is held unchanged
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(stage)));

   // R6: lane flags only take comma patterns the words can produce
   a_r6_kflag_shape: assert property (@(posedge clk) disable iff (rst)
      tx_valid |-> (tx_kflag == 4'h0 || tx_kflag == 4'h8 || tx_kflag == 4'hF));

   a_r6_kflag_quiet: assert property (@(posedge clk) disable iff (rst)
      !tx_valid |-> (tx_kflag == 4'h0));

   // R9: terminal state is sticky and silent
   a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
      loopback_reached |=> loopback_reached);

   a_r9_silent: assert property (@(posedge clk) disable iff (rst)
      loopback_reached |-> !tx_valid);

   // R1: idle offers nothing
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (stage == 3'd0) |-> (!tx_valid && !loopback_reached));

   // R2: leaving idle needs a start pulse
   a_r2_start_needed: assert property (@(posedge clk) disable iff (rst)
      ($past(stage) == 3'd0 && stage == 3'd1) |-> $past(start));

endmodule

// File: tb/lts_sequencer_test.sv
module lts_sequencer_test;

   localparam int EQR = 3;
   localparam int T1R = 2;
   localparam int T2R = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        loopback_req = 1'b0;
   logic        hot_reset_req = 1'b0;
   logic        tx_ready = 1'b0;
   logic        tx_valid;
   logic [31:0] tx_data;
   logic [3:0]  tx_kflag;
   logic [2:0]  stage;
   logic        loopback_reached;

   int total = 0;
   int fails = 0;
   int cycles = 0;

   int m_stage, m_word, m_rep;
   bit m_lb, m_hr;

   always #4 clk = ~clk;

   lts_sequencer #(.EQ_REPEATS(EQR), .TS1_REPEATS(T1R), .TS2_REPEATS(T2R)) uut (
      .clk (clk), .rst (rst), .start (start),
      .loopback_req (loopback_req), .hot_reset_req (hot_reset_req),
      .tx_ready (tx_ready), .tx_valid (tx_valid), .tx_data (tx_data),
      .tx_kflag (tx_kflag), .stage (stage), .loopback_reached (loopback_reached)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(int st, int idx, bit lb, bit hr);
      if (st == 1) begin
         case (idx)
            0: return 32'hBCFF17C0;
            1: return 32'h14B2E702;
            2: return 32'h82726E28;
            3: return 32'hA6BE6DBF;
            default: return 32'h4A4A4A4A;
         endcase
      end
      if (st == 2) begin
         case (idx)
            0: return 32'hBCBCBCBC;
            1: return 32'h00004A4A;
            default: return 32'h4A4A4A4A;
         endcase
      end
      if (st == 3) begin
         case (idx)
            0: return 32'hBCBCBCBC;
            1: return {8'h00, 5'd0, lb, 1'b0, hr, 16'h4545};
            default: return 32'h45454545;
         endcase
      end
      return 32'h0;
   endfunction

   function automatic logic [3:0] exp_k(logic [31:0] w);
      logic [3:0] k;
      for (int i = 0; i < 4; i++) k[i] = (w[8*i +: 8] == 8'hBC);
      return k;
   endfunction

   function automatic string req_of(int st);
      if (st == 1) return "R3";
      if (st == 2) return "R4";
      if (st == 3) return "R5";
      return "R8";
   endfunction

   task automatic check_now();
      bit v;
      logic [31:0] w;
      v = (m_stage >= 1 && m_stage <= 3);
      chk("R8", "stage", {29'd0, stage}, m_stage[31:0]);
      chk("R9", "loopback_reached", {31'd0, loopback_reached}, {31'd0, m_stage == 4});
      chk("R7", "tx_valid", {31'd0, tx_valid}, {31'd0, v});
      if (v) begin
         w = exp_word(m_stage, m_word, m_lb, m_hr);
         chk(req_of(m_stage), "tx_data", tx_data, w);
         chk("R6", "tx_kflag", {28'd0, tx_kflag}, {28'd0, exp_k(w)});
      end else begin
         chk("R6", "tx_kflag idle", {28'd0, tx_kflag}, 32'd0);
      end
   endtask

   task automatic model_advance();
      int wl, rl;
      wl = (m_stage == 1) ? 8 : 4;
      rl = (m_stage == 1) ? EQR : (m_stage == 2) ? T1R : T2R;
      if (m_word == wl - 1) begin
         m_word = 0;
         if (m_rep == rl - 1) begin
            m_rep = 0;
            m_stage++;
         end else m_rep++;
      end else m_word++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; start = 1'b0; tx_ready = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_stage = 0; m_word = 0; m_rep = 0; m_lb = 0; m_hr = 0;
      @(negedge clk);
      // R1: reset state
      check_now();
   endtask

   // pct: ready probability; pre_idle: idle cycles before start;
   // abort_at: stop after this many cycles (0 = run to end)
   task automatic run(bit lb, bit hr, int pct, int pre_idle, int abort_at);
      int n = 0;
      int tail = 0;
      bit r;
      bit v;
      for (int i = 0; i < pre_idle; i++) begin
         @(negedge clk);
         check_now();  // R2: no start, stays idle
      end
      while (tail < 6) begin
         @(negedge clk);
         check_now();
         v = (m_stage >= 1 && m_stage <= 3);
         if (n == 0) begin
            loopback_req = lb; hot_reset_req = hr; start = 1'b1;
         end else begin
            // R5: request inputs wander after capture; R2: stray start pulses
            loopback_req  = ($urandom % 2) == 1;
            hot_reset_req = ($urandom % 2) == 1;
            start = ($urandom % 5) == 0 || m_stage == 4;
         end
         r = ($urandom % 100) < pct;
         tx_ready = r;
         if (m_stage == 0 && start) begin
            m_stage = 1; m_word = 0; m_rep = 0;
            m_lb = loopback_req; m_hr = hot_reset_req;
         end else if (v && r) begin
            model_advance();
         end
         if (m_stage == 4) tail++;
         n++;
         if (abort_at != 0 && n >= abort_at) break;
      end
      @(negedge clk);
      start = 1'b0;
      check_now();
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++; fails++;
         $display("FAIL R7 watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      do_reset();
      run(1'b1, 1'b0, 100, 3, 0);   // full-rate, loopback request
      do_reset();
      run(1'b0, 1'b1, 50, 0, 0);    // half-rate back-pressure, hot reset
      do_reset();
      run(1'b1, 1'b1, 20, 1, 0);    // heavy stall, both bits
      do_reset();
      run(1'b0, 1'b0, 70, 0, 17);   // aborted mid-equalization
      do_reset();                   // R1: reset from active stage
      run(1'b0, 1'b0, 85, 2, 0);    // neither request
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule